// File: doc/BRIEF.md
# Video Region Crop and Decimation Filter

This block sits on a raw video pixel stream just ahead of the frame memory writer. It follows the stream's position from two qualifiers, frame-valid and line-valid. It counts the column inside each line and the line inside each frame. Pixels seen while either qualifier is low are blanking and are dropped.

From the active pixels it keeps only those that lie inside a programmed rectangle and that fall on the chosen horizontal and vertical decimation grid. The grid steps by a factor of 1, 2, 4 or 8, and each axis has its own factor. The grid starts at the rectangle's corner, so the top-left pixel of the rectangle is always kept. The same rules apply to every line and every frame.

The output is a valid-qualified pixel stream, one cycle behind the input. It carries a start-of-frame flag on the first kept pixel and an end-of-line flag on the last kept pixel of each kept line. The rectangle and the factors are taken from the configuration inputs only while frame-valid is low, so a new setting takes effect at the next frame boundary.

Top module: `vid_roi_decim`

## Requirements
- R1: A pixel can produce an output only in a cycle where both `in_fv` and `in_lv` are high. Pixels presented with `in_lv` high while `in_fv` is low are discarded.
- R2: The column index is the count of active pixels already seen in the current line, starting at 0. The row index is the count of falling edges of `in_lv` since `in_fv` rose, starting at 0. A pixel is kept only if its column is in [left, left+width) and its row is in [top, top+height).
- R3: `cfg_hscale` encodes the horizontal factor as 0→1, 1→2, 2→4, 3→8. Inside the rectangle, a pixel is kept only when (column − left) is a multiple of that factor.
- R4: `cfg_vscale` uses the same encoding for the vertical factor. Inside the rectangle, a line is kept only when (row − top) is a multiple of that factor.
- R5: The decimation phase restarts at the rectangle edge on every line and every frame, so the pixel at (left, top) is kept whenever width and height are both nonzero.
- R6: The configuration inputs are captured in every cycle where `in_fv` is low and are held while `in_fv` is high. A change made mid-frame has no effect until the next frame.
- R7: `out_sof` is high on the first kept pixel of a frame and on no other output.
- R8: `out_eol` is high on a kept pixel whose offset (column − left) equals (width − 1) rounded down to a multiple of the horizontal factor.
- R9: A kept input pixel shows up with `out_valid` high exactly one clock later, and `out_pix` carries the unchanged input value.
- R10: While `rst_n` is low, `out_valid`, `out_sof`, `out_eol` and `out_pix` are all 0.
- R11: If the captured width or height is 0, no pixel is output in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_fv | input | 1 | Frame-valid qualifier |
| in_lv | input | 1 | Line-valid qualifier |
| in_pix | input | PIX_W | Incoming pixel value |
| cfg_left | input | COORD_W | First column of the rectangle |
| cfg_top | input | COORD_W | First row of the rectangle |
| cfg_width | input | COORD_W | Rectangle width in source pixels |
| cfg_height | input | COORD_W | Rectangle height in source lines |
| cfg_hscale | input | 2 | Horizontal decimation code (0..3 → 1,2,4,8) |
| cfg_vscale | input | 2 | Vertical decimation code (0..3 → 1,2,4,8) |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | PIX_W | Output pixel value |
| out_sof | output | 1 | First kept pixel of the frame |
| out_eol | output | 1 | Last kept pixel of the line |

## Verification
A wrong column or row count shifts the whole kept grid. That shows as a `out_valid` mismatch on the first pixel of the affected line, one cycle after the pixel enters. A stale or wrongly held shadow setting shows up on the first line of the rectangle in the next frame. A lost start-of-frame pending flag shows as a missing or repeated `out_sof` on the first kept pixel. A bad end-of-line offset shows up on the first kept line. The bench runs a behavioural model and compares every output on every clock, so each such fault is caught in the cycle it first appears. It also checks the kept-pixel and start-of-frame totals at the end of each frame.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

  typedef enum logic [1:0] {
    SC_X1 = 2'd0,
    SC_X2 = 2'd1,
    SC_X4 = 2'd2,
    SC_X8 = 2'd3
  } scale_e;

  // low-bit mask of a power-of-two step: factor - 1
  function automatic logic [2:0] scale_mask(input logic [1:0] code);
    case (scale_e'(code))
      SC_X1:   scale_mask = 3'b000;
      SC_X2:   scale_mask = 3'b001;
      SC_X4:   scale_mask = 3'b011;
      default: scale_mask = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/vrd_pos_tracker.sv
module vrd_pos_tracker #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fv,
  input  logic               lv,
  output logic               active,
  output logic               line_end,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row
);
  logic lv_d;

  assign active   = fv & lv;
  assign line_end = lv_d & ~lv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_d <= 1'b0;
      col  <= '0;
      row  <= '0;
    end else begin
      lv_d <= lv;
      if (!lv)         col <= '0;
      else if (active) col <= col + 1'b1;
      if (!fv)           row <= '0;
      else if (line_end) row <= row + 1'b1;
    end
  end

  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !lv |=> (col == '0)); // R2

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fv |=> ((row == $past(row)) || (row == $past(row) + 1'b1))); // R2

  AST_ROW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fv |=> (row == '0)); // R2

endmodule

// File: rtl/vrd_cfg_shadow.sv
module vrd_cfg_shadow #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fv,
  input  logic [COORD_W-1:0] left_i,
  input  logic [COORD_W-1:0] top_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic [1:0]         hs_i,
  input  logic [1:0]         vs_i,
  output logic [COORD_W-1:0] left_o,
  output logic [COORD_W-1:0] top_o,
  output logic [COORD_W-1:0] width_o,
  output logic [COORD_W-1:0] height_o,
  output logic [1:0]         hs_o,
  output logic [1:0]         vs_o
);
  logic capture;
  assign capture = ~fv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_o   <= '0;
      top_o    <= '0;
      width_o  <= '0;
      height_o <= '0;
      hs_o     <= '0;
      vs_o     <= '0;
    end else if (capture) begin
      left_o   <= left_i;
      top_o    <= top_i;
      width_o  <= width_i;
      height_o <= height_i;
      hs_o     <= hs_i;
      vs_o     <= vs_i;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fv |=> ($stable(left_o) && $stable(top_o) && $stable(width_o) &&
            $stable(height_o) && $stable(hs_o) && $stable(vs_o))); // R6

endmodule

// File: rtl/vrd_window_sel.sv
module vrd_window_sel #(
  parameter int COORD_W = 12
) (
  input  logic               active,
  input  logic [COORD_W-1:0] col,
  input  logic [COORD_W-1:0] row,
  input  logic [COORD_W-1:0] left,
  input  logic [COORD_W-1:0] top,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [1:0]         hs,
  input  logic [1:0]         vs,
  output logic               keep,
  output logic               last_in_line
);
  import vrd_pkg::*;

  localparam int EXT_W = COORD_W + 1;

  logic [EXT_W-1:0]   x_end, y_end;
  logic               in_x, in_y, ph_x, ph_y;
  logic [COORD_W-1:0] dx, dy, hmask, vmask, last_off;

  always_comb begin
    x_end    = {1'b0, left} + {1'b0, width};
    y_end    = {1'b0, top}  + {1'b0, height};
    in_x     = (col >= left) && ({1'b0, col} < x_end);
    in_y     = (row >= top)  && ({1'b0, row} < y_end);
    dx       = col - left;
    dy       = row - top;
    hmask    = COORD_W'(scale_mask(hs));
    vmask    = COORD_W'(scale_mask(vs));
    ph_x     = ((dx & hmask) == '0);
    ph_y     = ((dy & vmask) == '0);
    last_off = (width - 1'b1) & ~hmask;
    keep         = active && in_x && in_y && ph_x && ph_y;
    last_in_line = (dx == last_off);
  end

endmodule

// File: rtl/vid_roi_decim.sv
module vid_roi_decim #(
  parameter int PIX_W   = 10,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_fv,
  input  logic               in_lv,
  input  logic [PIX_W-1:0]   in_pix,
  input  logic [COORD_W-1:0] cfg_left,
  input  logic [COORD_W-1:0] cfg_top,
  input  logic [COORD_W-1:0] cfg_width,
  input  logic [COORD_W-1:0] cfg_height,
  input  logic [1:0]         cfg_hscale,
  input  logic [1:0]         cfg_vscale,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_pix,
  output logic               out_sof,
  output logic               out_eol
);
  logic               pix_active, line_end;
  logic [COORD_W-1:0] pos_col, pos_row;
  logic [COORD_W-1:0] sh_left, sh_top, sh_width, sh_height;
  logic [1:0]         sh_hs, sh_vs;
  logic               keep, last_in_line, sof_pending;

  vrd_pos_tracker #(.COORD_W(COORD_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .fv(in_fv), .lv(in_lv),
    .active(pix_active), .line_end(line_end),
    .col(pos_col), .row(pos_row)
  );

  vrd_cfg_shadow #(.COORD_W(COORD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .fv(in_fv),
    .left_i(cfg_left), .top_i(cfg_top), .width_i(cfg_width),
    .height_i(cfg_height), .hs_i(cfg_hscale), .vs_i(cfg_vscale),
    .left_o(sh_left), .top_o(sh_top), .width_o(sh_width),
    .height_o(sh_height), .hs_o(sh_hs), .vs_o(sh_vs)
  );

  vrd_window_sel #(.COORD_W(COORD_W)) u_sel (
    .active(pix_active), .col(pos_col), .row(pos_row),
    .left(sh_left), .top(sh_top), .width(sh_width), .height(sh_height),
    .hs(sh_hs), .vs(sh_vs),
    .keep(keep), .last_in_line(last_in_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pix     <= '0;
      out_sof     <= 1'b0;
      out_eol     <= 1'b0;
      sof_pending <= 1'b1;
    end else begin
      out_valid <= keep;
      out_pix   <= in_pix;
      out_sof   <= keep & sof_pending;
      out_eol   <= keep & last_in_line;
      if (!in_fv)    sof_pending <= 1'b1;
      else if (keep) sof_pending <= 1'b0;
    end
  end

  AST_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_fv && in_lv)); // R1

  AST_PIX_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pix == $past(in_pix))); // R9

  AST_SOF_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R7

  AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |=> !out_sof); // R7

  AST_EOL_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid); // R8

  AST_NO_BLANK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_fv |=> !out_valid); // R1

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_sof && !out_eol)); // R10

endmodule

// File: tb/vid_roi_decim_tb_top.sv
module vid_roi_decim_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 10;
  localparam int COORD_W    = 12;
  localparam int PPL        = 20;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_fv = 1'b0, in_lv = 1'b0;
  logic [PIX_W-1:0]   in_pix = '0;
  logic [COORD_W-1:0] cfg_left = '0, cfg_top = '0, cfg_width = '0, cfg_height = '0;
  logic [1:0]         cfg_hscale = '0, cfg_vscale = '0;
  logic               out_valid, out_sof, out_eol;
  logic [PIX_W-1:0]   out_pix;

  vid_roi_decim #(.PIX_W(PIX_W), .COORD_W(COORD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_fv(in_fv), .in_lv(in_lv), .in_pix(in_pix),
    .cfg_left(cfg_left), .cfg_top(cfg_top), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_hscale(cfg_hscale), .cfg_vscale(cfg_vscale),
    .out_valid(out_valid), .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0, bad = 0;
  string cur_req = "R1";
  bit    run_chk = 1'b0;
  int    frame_cnt = 0, sof_cnt = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_col, m_row, m_plv, m_pend;
  int s_l, s_t, s_w, s_h, s_hf, s_vf;
  int e_valid, e_sof, e_eol, e_pix;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_col = 0; m_row = 0; m_plv = 0; m_pend = 1;
      s_l = 0; s_t = 0; s_w = 0; s_h = 0; s_hf = 1; s_vf = 1;
      e_valid = 0; e_sof = 0; e_eol = 0; e_pix = 0;
    end else begin
      e_valid = 0; e_sof = 0; e_eol = 0; e_pix = int'(in_pix);
      if (!in_fv) begin
        s_l = int'(cfg_left); s_t = int'(cfg_top);
        s_w = int'(cfg_width); s_h = int'(cfg_height);
        s_hf = 1 << cfg_hscale; s_vf = 1 << cfg_vscale;
        m_pend = 1;
      end else if (in_lv) begin
        if (m_col >= s_l && m_col < s_l + s_w && m_row >= s_t && m_row < s_t + s_h &&
            ((m_col - s_l) % s_hf) == 0 && ((m_row - s_t) % s_vf) == 0) begin
          e_valid = 1;
          e_sof   = m_pend;
          m_pend  = 0;
          e_eol   = ((m_col - s_l) == ((s_w - 1) / s_hf) * s_hf) ? 1 : 0;
        end
      end
      if (!in_lv) m_col = 0;
      else if (in_fv) m_col++;
      if (!in_fv) m_row = 0;
      else if (m_plv == 1 && !in_lv) m_row++;
      m_plv = in_lv ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk(cur_req, "valid", int'(out_valid), e_valid);
      if (e_valid == 1 && out_valid) begin
        chk("R9", "pix", int'(out_pix), e_pix);
        chk("R7", "sof", int'(out_sof), e_sof);
        chk("R8", "eol", int'(out_eol), e_eol);
      end
      if (out_valid) frame_cnt++;
      if (out_sof) sof_cnt++;
    end
  end

  task automatic set_cfg(input int l, input int t, input int w, input int h,
                         input int hs, input int vs);
    cfg_left = COORD_W'(l); cfg_top = COORD_W'(t);
    cfg_width = COORD_W'(w); cfg_height = COORD_W'(h);
    cfg_hscale = 2'(hs); cfg_vscale = 2'(vs);
  endtask

  task automatic send_frame(input int nlines, input bit midchg, input bit stray);
    frame_cnt = 0; sof_cnt = 0;
    if (stray) begin
      for (int i = 0; i < 3; i++) begin
        in_lv = 1'b1; in_pix = PIX_W'(900 + i);
        @(negedge clk);
      end
      in_lv = 1'b0;
      repeat (2) @(negedge clk);
    end
    in_fv = 1'b1;
    repeat (2) @(negedge clk);
    for (int l = 0; l < nlines; l++) begin
      for (int c = 0; c < PPL; c++) begin
        in_lv = 1'b1;
        in_pix = PIX_W'(l * 37 + c * 5 + 1);
        @(negedge clk);
      end
      in_lv = 1'b0;
      if (midchg && l == 1) begin
        cfg_left = cfg_left + 2;
        cfg_hscale = 2'd0;
      end
      repeat (3) @(negedge clk);
    end
    in_fv = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  function automatic int exp_cnt(input int w, input int h, input int hs, input int vs);
    int f = 1 << hs;
    int g = 1 << vs;
    if (w == 0 || h == 0) return 0;
    return ((w + f - 1) / f) * ((h + g - 1) / g);
  endfunction

  task automatic frame_case(input string req, input int l, input int t, input int w,
                            input int h, input int hs, input int vs, input int nl,
                            input bit stray);
    cur_req = req;
    set_cfg(l, t, w, h, hs, vs);
    @(negedge clk);
    send_frame(nl, 1'b0, stray);
    chk(req, "kept count", frame_cnt, exp_cnt(w, h, hs, vs));
    chk("R7", "sof count", sof_cnt, (exp_cnt(w, h, hs, vs) > 0) ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL R10 watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs quiet under reset
    chk("R10", "valid in reset", int'(out_valid), 0);
    chk("R10", "sof in reset", int'(out_sof), 0);
    chk("R10", "eol in reset", int'(out_eol), 0);
    chk("R10", "pix in reset", int'(out_pix), 0);
    rst_n = 1'b1;
    run_chk = 1'b1;
    @(negedge clk);

    frame_case("R1", 0, 0, PPL, 6, 0, 0, 6, 1'b1);   // full pass, stray blanking pixels
    frame_case("R2", 3, 2, 10, 3, 0, 0, 7, 1'b0);    // crop only
    frame_case("R3", 1, 0, 13, 4, 1, 0, 5, 1'b0);    // step 2 across, odd width
    frame_case("R4", 0, 1, 8, 9, 0, 2, 12, 1'b0);    // step 4 down
    frame_case("R5", 5, 2, 12, 10, 3, 3, 14, 1'b0);  // step 8 both, corner kept
    frame_case("R3", 2, 1, 16, 4, 2, 1, 6, 1'b0);    // step 4 across, step 2 down

    // R6: mid-frame change ignored, taken at the next frame
    cur_req = "R6";
    set_cfg(4, 0, 8, 4, 1, 0);
    @(negedge clk);
    send_frame(5, 1'b1, 1'b0);
    chk("R6", "kept count mid-change", frame_cnt, exp_cnt(8, 4, 1, 0));
    send_frame(5, 1'b0, 1'b0);
    chk("R6", "kept count next frame", frame_cnt, exp_cnt(8, 4, 0, 0));

    // R11: empty rectangle
    frame_case("R11", 2, 1, 0, 4, 0, 0, 5, 1'b0);
    frame_case("R11", 2, 1, 6, 0, 0, 0, 5, 1'b0);

    run_chk = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule